// File: doc/BRIEF.md
# Register Rename Map Table

This block holds the architectural-to-physical register mapping for an out-of-order core. One architectural index space is split into three ranges. The lowest indices are integer registers, the next range is floating-point registers, and everything above that is a set of miscellaneous registers that are never renamed. Integer and float mappings live in separate tables. Each class has its own circular free list of physical registers. Float physical numbers follow the integer ones.

The rename port is combinational. It returns the new and the previous mapping, and the table and free lists change at the next clock edge. The lookup port is read-only. The set-entry port overwrites one mapping, for recovery or commit. A single release port returns physical registers: it sends each index to the free list that owns its range and drops any index at or above the total physical count. The block also reports how many renames can still proceed, which is the smaller of the two free counts.

Top module: `rename_map_table`

## Requirements
- R1: Index decode uses the default sizes. Arch 0..7 are integer, arch 8..15 are float and arch 16..19 are misc. Integer physical registers are 0..15, float physical registers are 16..31, and misc registers map to 32..35.
- R2: A rename of a non-zero integer register returns the head of the integer free list as renNew and the current entry as renPrev. The new value always lies in 0..15, and the table holds it from the next cycle.
- R3: A rename of the integer zero register (arch 0) never stalls. It allocates nothing and leaves the table unchanged. It returns 0 as renNew and the current entry as renPrev.
- R4: A float rename takes renNew from the float free list, in the range 16..31. When FP_ZERO_EN is 1 (the default), the float zero register (arch 8) is exempt: it returns 8 as renNew and the current entry as renPrev.
- R5: A misc index a is never renamed. Both renNew and renPrev equal (a − 16) + 32.
- R6: lkPhys returns the current integer or float mapping, or the fixed misc offset. A write in the same cycle is visible only from the following cycle.
- R7: A set-entry to an integer or float index overwrites that entry, and a set-entry to a misc index is ignored. When a set-entry and a rename hit the same index in one cycle, the set value is stored and the rename still consumes its free register.
- R8: availCount equals the smaller of the integer and float free-list counts.
- R9: After reset, integer arch i maps to i and float arch 8+j maps to 16+j. The integer free list hands out 8..15 in ascending order, and the float free list hands out 24..31 in ascending order.
- R10: A released index below 16 is appended to the tail of the integer list, and an index from 16 to 31 is appended to the tail of the float list. An index of 32 or above is dropped.
- R11: A rename that needs an empty list raises renStall. The table is not changed and nothing is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request |
| renArch | input | 5 | Architectural index to rename |
| renNew | output | 6 | New physical mapping |
| renPrev | output | 6 | Previous physical mapping |
| renStall | output | 1 | Rename blocked by an empty free list |
| lkArch | input | 5 | Lookup index |
| lkPhys | output | 6 | Current mapping of lkArch |
| setValid | input | 1 | Set-entry request |
| setArch | input | 5 | Index to overwrite |
| setPhys | input | 6 | Value to write |
| relValid | input | 1 | Release request |
| relIdx | input | 6 | Physical index being released |
| availCount | output | 5 | Minimum of the two free counts |

## Verification
A lookup can fall in the same cycle as a set-entry or rename write to the same index. The bench holds the lookup on the written index through the write cycle and expects the old value, then the new value one cycle later. A set-entry and a rename to the same index are also issued together: the bench expects the set value in the table and the next allocation to skip the consumed register. A release is likewise issued together with a stalled rename on an empty list, and the bench expects the stall and a free count of one afterwards.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } regcls_e;

  typedef struct packed {
    regcls_e renCls;
    logic    renZero;
    regcls_e lkCls;
    logic    intAlloc;
    logic    fpAlloc;
    logic    setInt;
    logic    setFp;
    logic    relInt;
    logic    relFp;
  } ctrl_t;

endpackage

// File: rtl/rmt_freelist.sv
module rmt_freelist #(
  parameter int DEPTH    = 16,
  parameter int PHYS_W   = 6,
  parameter int FIRST    = 8,
  parameter int INIT_CNT = 8,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [PHYS_W-1:0] pushIdx,
  output logic [PHYS_W-1:0] headIdx,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PHYS_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;
  logic              doPop, doPush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPop   = pop && (cnt != '0);
  assign doPush  = push && (cnt != CNT_W'(DEPTH));
  assign headIdx = slots[head];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++)
        slots[k] <= (k < INIT_CNT) ? PHYS_W'(FIRST + k) : '0;
      head <= '0;
      tail <= PTR_W'(INIT_CNT % DEPTH);
      cnt  <= CNT_W'(INIT_CNT);
    end else begin
      if (doPush) begin
        slots[tail] <= pushIdx;
        tail        <= nextPtr(tail);
      end
      if (doPop) head <= nextPtr(head);
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rmt_ctrl.sv
module rmt_ctrl
  import rmt_pkg::*;
#(
  parameter int NUM_LOG_INT  = 8,
  parameter int NUM_LOG_FP   = 8,
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int INT_ZERO     = 0,
  parameter int FP_ZERO      = 8,
  parameter bit FP_ZERO_EN   = 1'b1,
  parameter int ARCH_W       = 5,
  parameter int PHYS_W       = 6
) (
  input  logic              renValid,
  input  logic [ARCH_W-1:0] renArch,
  input  logic [ARCH_W-1:0] lkArch,
  input  logic              setValid,
  input  logic [ARCH_W-1:0] setArch,
  input  logic              relValid,
  input  logic [PHYS_W-1:0] relIdx,
  input  logic              intEmpty,
  input  logic              fpEmpty,
  output ctrl_t             strobes,
  output logic              renStall
);
  localparam int LOG_TOTAL  = NUM_LOG_INT + NUM_LOG_FP;
  localparam int PHYS_TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;

  function automatic regcls_e classOf(input logic [ARCH_W-1:0] a);
    if (int'(a) < NUM_LOG_INT)   return CLS_INT;
    else if (int'(a) < LOG_TOTAL) return CLS_FP;
    else                          return CLS_MISC;
  endfunction

  regcls_e renCls, setCls;
  logic    renZero, needInt, needFp;

  always_comb begin
    renCls  = classOf(renArch);
    setCls  = classOf(setArch);
    renZero = ((renCls == CLS_INT) && (int'(renArch) == INT_ZERO)) ||
              (FP_ZERO_EN && (renCls == CLS_FP) && (int'(renArch) == FP_ZERO));
    needInt = renValid && (renCls == CLS_INT) && !renZero;
    needFp  = renValid && (renCls == CLS_FP) && !renZero;
    renStall = (needInt && intEmpty) || (needFp && fpEmpty);

    strobes.renCls   = renCls;
    strobes.renZero  = renZero;
    strobes.lkCls    = classOf(lkArch);
    strobes.intAlloc = needInt && !intEmpty;
    strobes.fpAlloc  = needFp && !fpEmpty;
    strobes.setInt   = setValid && (setCls == CLS_INT);
    strobes.setFp    = setValid && (setCls == CLS_FP);
    strobes.relInt   = relValid && (int'(relIdx) < NUM_PHYS_INT);
    strobes.relFp    = relValid && (int'(relIdx) >= NUM_PHYS_INT) &&
                       (int'(relIdx) < PHYS_TOTAL);
  end
endmodule

// File: rtl/rmt_datapath.sv
module rmt_datapath
  import rmt_pkg::*;
#(
  parameter int NUM_LOG_INT  = 8,
  parameter int NUM_LOG_FP   = 8,
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int INT_ZERO     = 0,
  parameter int FP_ZERO      = 8,
  parameter int ARCH_W       = 5,
  parameter int PHYS_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             strobes,
  input  logic [ARCH_W-1:0] renArch,
  input  logic [ARCH_W-1:0] lkArch,
  input  logic [ARCH_W-1:0] setArch,
  input  logic [PHYS_W-1:0] setPhys,
  input  logic [PHYS_W-1:0] intHead,
  input  logic [PHYS_W-1:0] fpHead,
  output logic [PHYS_W-1:0] renNew,
  output logic [PHYS_W-1:0] renPrev,
  output logic [PHYS_W-1:0] lkPhys
);
  localparam int LOG_TOTAL  = NUM_LOG_INT + NUM_LOG_FP;
  localparam int PHYS_TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;

  logic [PHYS_W-1:0] intTab [NUM_LOG_INT];
  logic [PHYS_W-1:0] fpTab  [NUM_LOG_FP];

  function automatic logic [PHYS_W-1:0] miscPhys(input logic [ARCH_W-1:0] a);
    return PHYS_W'(int'(a) - LOG_TOTAL + PHYS_TOTAL);
  endfunction

  function automatic logic [PHYS_W-1:0] readMap(input logic [ARCH_W-1:0] a,
                                                input regcls_e c);
    logic [PHYS_W-1:0] r;
    r = miscPhys(a);
    if (c == CLS_INT) begin
      for (int e = 0; e < NUM_LOG_INT; e++)
        if (int'(a) == e) r = intTab[e];
    end else if (c == CLS_FP) begin
      for (int e = 0; e < NUM_LOG_FP; e++)
        if (int'(a) == e + NUM_LOG_INT) r = fpTab[e];
    end
    return r;
  endfunction

  always_comb begin
    renPrev = readMap(renArch, strobes.renCls);
    lkPhys  = readMap(lkArch, strobes.lkCls);
    unique case (strobes.renCls)
      CLS_INT:  renNew = strobes.renZero ? PHYS_W'(INT_ZERO) : intHead;
      CLS_FP:   renNew = strobes.renZero ? PHYS_W'(FP_ZERO) : fpHead;
      default:  renNew = miscPhys(renArch);
    endcase
  end

  for (genvar g = 0; g < NUM_LOG_INT; g++) begin : gIntEntry
    always_ff @(posedge clk) begin
      if (!rst_n)
        intTab[g] <= PHYS_W'(g);
      else if (strobes.setInt && int'(setArch) == g)
        intTab[g] <= setPhys;
      else if (strobes.intAlloc && int'(renArch) == g)
        intTab[g] <= intHead;
    end
  end

  for (genvar g = 0; g < NUM_LOG_FP; g++) begin : gFpEntry
    always_ff @(posedge clk) begin
      if (!rst_n)
        fpTab[g] <= PHYS_W'(NUM_PHYS_INT + g);
      else if (strobes.setFp && int'(setArch) == g + NUM_LOG_INT)
        fpTab[g] <= setPhys;
      else if (strobes.fpAlloc && int'(renArch) == g + NUM_LOG_INT)
        fpTab[g] <= fpHead;
    end
  end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmt_pkg::*;
#(
  parameter int NUM_LOG_INT  = 8,
  parameter int NUM_LOG_FP   = 8,
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int NUM_MISC     = 4,
  parameter int INT_ZERO     = 0,
  parameter int FP_ZERO      = 8,
  parameter bit FP_ZERO_EN   = 1'b1,
  parameter int ARCH_W       = $clog2(NUM_LOG_INT + NUM_LOG_FP + NUM_MISC),
  parameter int PHYS_W       = $clog2(NUM_PHYS_INT + NUM_PHYS_FP + NUM_MISC),
  parameter int CNT_W        = $clog2((NUM_PHYS_INT > NUM_PHYS_FP ?
                                       NUM_PHYS_INT : NUM_PHYS_FP) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renValid,
  input  logic [ARCH_W-1:0] renArch,
  output logic [PHYS_W-1:0] renNew,
  output logic [PHYS_W-1:0] renPrev,
  output logic              renStall,
  input  logic [ARCH_W-1:0] lkArch,
  output logic [PHYS_W-1:0] lkPhys,
  input  logic              setValid,
  input  logic [ARCH_W-1:0] setArch,
  input  logic [PHYS_W-1:0] setPhys,
  input  logic              relValid,
  input  logic [PHYS_W-1:0] relIdx,
  output logic [CNT_W-1:0]  availCount
);
  localparam int INT_CW = $clog2(NUM_PHYS_INT + 1);
  localparam int FP_CW  = $clog2(NUM_PHYS_FP + 1);

  ctrl_t             strobes;
  logic [PHYS_W-1:0] intHead, fpHead;
  logic [INT_CW-1:0] intCount;
  logic [FP_CW-1:0]  fpCount;
  logic [CNT_W-1:0]  intCountW, fpCountW;

  rmt_ctrl #(
    .NUM_LOG_INT(NUM_LOG_INT), .NUM_LOG_FP(NUM_LOG_FP),
    .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
    .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .FP_ZERO_EN(FP_ZERO_EN),
    .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) u_ctrl (
    .renValid(renValid), .renArch(renArch), .lkArch(lkArch),
    .setValid(setValid), .setArch(setArch),
    .relValid(relValid), .relIdx(relIdx),
    .intEmpty(intCount == '0), .fpEmpty(fpCount == '0),
    .strobes(strobes), .renStall(renStall)
  );

  rmt_datapath #(
    .NUM_LOG_INT(NUM_LOG_INT), .NUM_LOG_FP(NUM_LOG_FP),
    .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
    .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO),
    .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .renArch(renArch), .lkArch(lkArch),
    .setArch(setArch), .setPhys(setPhys),
    .intHead(intHead), .fpHead(fpHead),
    .renNew(renNew), .renPrev(renPrev), .lkPhys(lkPhys)
  );

  rmt_freelist #(
    .DEPTH(NUM_PHYS_INT), .PHYS_W(PHYS_W), .FIRST(NUM_LOG_INT),
    .INIT_CNT(NUM_PHYS_INT - NUM_LOG_INT), .CNT_W(INT_CW)
  ) u_intFree (
    .clk(clk), .rst_n(rst_n),
    .pop(strobes.intAlloc), .push(strobes.relInt), .pushIdx(relIdx),
    .headIdx(intHead), .count(intCount)
  );

  rmt_freelist #(
    .DEPTH(NUM_PHYS_FP), .PHYS_W(PHYS_W), .FIRST(NUM_PHYS_INT + NUM_LOG_FP),
    .INIT_CNT(NUM_PHYS_FP - NUM_LOG_FP), .CNT_W(FP_CW)
  ) u_fpFree (
    .clk(clk), .rst_n(rst_n),
    .pop(strobes.fpAlloc), .push(strobes.relFp), .pushIdx(relIdx),
    .headIdx(fpHead), .count(fpCount)
  );

  assign intCountW  = CNT_W'(intCount);
  assign fpCountW   = CNT_W'(fpCount);
  assign availCount = (intCountW < fpCountW) ? intCountW : fpCountW;
endmodule

// File: rtl/rename_map_table_checker.sv
module rename_map_table_checker #(
  parameter int NUM_LOG_INT  = 8,
  parameter int NUM_LOG_FP   = 8,
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int INT_ZERO     = 0,
  parameter int ARCH_W       = 5,
  parameter int PHYS_W       = 6,
  parameter int CNT_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              renValid,
  input logic [ARCH_W-1:0] renArch,
  input logic [PHYS_W-1:0] renNew,
  input logic [PHYS_W-1:0] renPrev,
  input logic              renStall,
  input logic [CNT_W-1:0]  availCount
);
  localparam int LOG_TOTAL  = NUM_LOG_INT + NUM_LOG_FP;
  localparam int PHYS_TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;

  logic intReq, fpReq, miscReq;
  assign intReq  = renValid && int'(renArch) < NUM_LOG_INT && int'(renArch) != INT_ZERO;
  assign fpReq   = renValid && int'(renArch) >= NUM_LOG_INT && int'(renArch) < LOG_TOTAL;
  assign miscReq = renValid && int'(renArch) >= LOG_TOTAL;

  assert_int_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (intReq && !renStall) |-> int'(renNew) < NUM_PHYS_INT);

  assert_fp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fpReq && !renStall && renNew != PHYS_W'(NUM_LOG_INT)) |->
      (int'(renNew) >= NUM_PHYS_INT && int'(renNew) < PHYS_TOTAL));

  assert_zero_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && int'(renArch) == INT_ZERO) |-> (!renStall && int'(renNew) == INT_ZERO));

  assert_misc_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miscReq |-> (renNew == renPrev && !renStall));

  assert_stall_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    renStall |-> (renValid && availCount == '0));
endmodule

bind rename_map_table rename_map_table_checker #(
  .NUM_LOG_INT(NUM_LOG_INT), .NUM_LOG_FP(NUM_LOG_FP),
  .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
  .INT_ZERO(INT_ZERO), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .renValid(renValid), .renArch(renArch),
  .renNew(renNew), .renPrev(renPrev), .renStall(renStall),
  .availCount(availCount)
);

// File: tb/rename_map_table_bench.sv
module rename_map_table_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       renValid;
  logic [4:0] renArch;
  logic [5:0] renNew, renPrev;
  logic       renStall;
  logic [4:0] lkArch;
  logic [5:0] lkPhys;
  logic       setValid;
  logic [4:0] setArch;
  logic [5:0] setPhys;
  logic       relValid;
  logic [5:0] relIdx;
  logic [4:0] availCount;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rename_map_table u_rename_map_table (
    .clk(clk), .rst_n(rst_n),
    .renValid(renValid), .renArch(renArch),
    .renNew(renNew), .renPrev(renPrev), .renStall(renStall),
    .lkArch(lkArch), .lkPhys(lkPhys),
    .setValid(setValid), .setArch(setArch), .setPhys(setPhys),
    .relValid(relValid), .relIdx(relIdx),
    .availCount(availCount)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle();
    renValid = 0; setValid = 0; relValid = 0;
  endtask

  // advance one clock, re-sample one time unit after the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic lookupIs(input string req, input int arch, input int phys);
    lkArch = 5'(arch);
    #1;
    check(req, int'(lkPhys), phys);
  endtask

  task automatic renameIs(input string req, input int arch, input int expNew,
                          input int expPrev, input bit expStall);
    renValid = 1; renArch = 5'(arch);
    #1;
    check({req, " stall"}, int'(renStall), int'(expStall));
    if (!expStall) begin
      check({req, " new"}, int'(renNew), expNew);
      check({req, " prev"}, int'(renPrev), expPrev);
    end
  endtask

  task automatic testReset();
    for (int i = 0; i < 8; i++) lookupIs("R9 int bind", i, i);
    for (int j = 0; j < 8; j++) lookupIs("R9 fp bind", 8 + j, 16 + j);
    lookupIs("R1 misc lookup", 16, 32);
    lookupIs("R6 misc lookup", 19, 35);
    check("R9 avail", int'(availCount), 8);
    check("R11 no stall idle", int'(renStall), 0);
  endtask

  task automatic testIntRename();
    renameIs("R2 int", 3, 8, 3, 0);
    step();
    lookupIs("R2 table updated", 3, 8);
    check("R8 avail after int", int'(availCount), 7);
  endtask

  task automatic testZero();
    renameIs("R3 zero", 0, 0, 0, 0);
    step();
    lookupIs("R3 zero unchanged", 0, 0);
    check("R3 no alloc", int'(availCount), 7);
    renameIs("R3 next int", 5, 9, 5, 0);
    step();
  endtask

  task automatic testFloat();
    renameIs("R4 fp", 9, 24, 17, 0);
    step();
    lookupIs("R4 fp table", 9, 24);
    renameIs("R4 fp zero", 8, 8, 16, 0);
    step();
    lookupIs("R4 fp zero unchanged", 8, 16);
    check("R8 avail min", int'(availCount), 6);
  endtask

  task automatic testMisc();
    renameIs("R5 misc", 18, 34, 34, 0);
    step();
    lookupIs("R5 misc lookup", 18, 34);
    check("R5 no alloc", int'(availCount), 6);
  endtask

  task automatic testSetEntry();
    setValid = 1; setArch = 5'd3; setPhys = 6'd2;
    lookupIs("R6 pre-write view", 3, 8);
    step();
    lookupIs("R7 set int", 3, 2);
    setValid = 1; setArch = 5'd17; setPhys = 6'd5;
    step();
    lookupIs("R7 misc set ignored", 17, 33);
    renameIs("R7 set+rename", 4, 10, 4, 0);
    setValid = 1; setArch = 5'd4; setPhys = 6'd7;
    lookupIs("R6 same cycle rename", 4, 4);
    step();
    lookupIs("R7 set wins", 4, 7);
    check("R7 rename consumed", int'(availCount), 5);
  endtask

  task automatic testRelease();
    relValid = 1; relIdx = 6'd40;
    step();
    check("R10 drop high", int'(availCount), 5);
    relValid = 1; relIdx = 6'd3;
    step();
    check("R10 int release", int'(availCount), 6);
    relValid = 1; relIdx = 6'd20;
    step();
    check("R10 fp release", int'(availCount), 6);
  endtask

  task automatic testStall();
    int expect_new [6] = '{11, 12, 13, 14, 15, 3};
    int prevVal = 1;
    for (int k = 0; k < 6; k++) begin
      renameIs("R10 fifo order", 1, expect_new[k], prevVal, 0);
      prevVal = expect_new[k];
      step();
    end
    check("R8 int empty", int'(availCount), 0);
    renameIs("R11 stall", 2, 0, 0, 1);
    relValid = 1; relIdx = 6'd12;
    step();
    lookupIs("R11 table kept", 2, 2);
    check("R11 release during stall", int'(availCount), 1);
    renameIs("R11 after release", 2, 12, 2, 0);
    step();
  endtask

  initial begin
    idle();
    renArch = '0; lkArch = '0; setArch = '0; setPhys = '0; relIdx = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    testReset();
    testIntRename();
    testZero();
    testFloat();
    testMisc();
    testSetEntry();
    testRelease();
    testStall();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule